// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 10-bit successive-approximation converter. Software controls it through four byte-wide register addresses. One control byte carries a combined go/busy bit, an enable bit, a justification select, a conversion clock divider select and a sticky completion flag. Two further addresses hold the 16-bit result as a high byte and a low byte.

When a conversion is requested, the sequencer opens the sample-and-hold switch and waits one conversion period. It then resolves the code from the most significant bit down, one bit per conversion period, using a trial code that it drives to an external DAC and a single comparator input. On the last bit it loads the result pair in the selected justification, drops the busy bit, raises the flag and closes the hold switch again. Software can cancel a running conversion by writing the go bit low. The old result then stays in place, and the hold switch stays open for a fixed two-period recovery. While the converter is disabled, software may use the two result bytes as plain storage.

Top module: `sar_seq_top`

## Requirements
- R1: A control write (address 0) with go (bit 0) = 1 and enable (bit 1) = 1, made while enable is already 1 and the sequencer is idle, starts a conversion. From the next cycle the go/busy bit reads 1 and `sh_track` is 0.
- R2: The conversion period is 2^(sel+1) system clocks, where sel is control bits 4:3 (divisor 2, 4, 8 or 16). The busy bit falls exactly 11 conversion periods after the start write: one setup period and then ten bit periods.
- R3: After the setup period, `dac_code` holds 0x200. At each bit period the bit under test is kept if `cmp_hi` = 1 (input at or above `dac_code`) and cleared otherwise, and the next lower bit is set as the new trial. The final code equals the input level that the comparator represents.
- R4: In the cycle that busy falls, the result pair already holds the new code, `irq` and control bit 7 read 1, and `sh_track` reads 1.
- R5: When format select (control bit 2) = 1, the result is right justified: the high byte (address 2) is {6 zeros, code[9:8]} and the low byte (address 3) is code[7:0].
- R6: When format select = 0, the result is left justified: the high byte is code[9:2] and the low byte is {code[1:0], 6 zeros}.
- R7: A control write with go = 0 during a conversion aborts it. Busy reads 0 from the next cycle, the result pair is unchanged and the flag is not set.
- R8: After an abort, `sh_track` stays 0 for exactly 2 conversion periods after the abort write and then returns to 1. A start request made during this recovery is ignored.
- R9: While enable reads 0, writes to addresses 2 and 3 store the written bytes and read back unchanged. While enable reads 1, software writes to those addresses are ignored.
- R10: A control write that sets go = 1 in the same write that changes enable from 0 to 1 does not start a conversion.
- R11: The flag (control bit 7, also driven on `irq`) is cleared only by a control write with bit 7 = 0. Writing bit 7 = 1 leaves it unchanged, and a completing conversion sets it whether or not it was already set.
- R12: While enable is 0, a go request is ignored: busy stays 0 and `sh_track` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 2 result high, 3 result low |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| cmp_hi | input | 1 | Comparator: 1 when the held input is at or above the DAC level |
| dac_code | output | 10 | Trial code for the external DAC |
| sh_track | output | 1 | 1 = hold capacitor connected to the input, 0 = disconnected |
| irq | output | 1 | Sticky completion flag |

## Verification
The assertions assume that the comparator input is a settled function of `dac_code` at every divider tick and that the divider select does not change while a conversion runs. The bench keeps within both assumptions. It derives `cmp_hi` combinationally from a fixed input level and `dac_code`, and it writes the divider field only as part of the write that starts a conversion. The register write strobe is assumed to be one cycle wide, with stable address and data. The bench drives all writes on the falling edge, so each write is captured by exactly one rising edge.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_BITS  = 2'd2,
    ST_RECOV = 2'd3
  } sar_state_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_RHI  = 2'd2;
  localparam logic [1:0] ADDR_RLO  = 2'd3;

  localparam int unsigned CB_GO  = 0;
  localparam int unsigned CB_EN  = 1;
  localparam int unsigned CB_FMT = 2;
  localparam int unsigned CB_DIV = 3;
  localparam int unsigned CB_IRQ = 7;

endpackage

// File: rtl/sar_clkdiv.sv
module sar_clkdiv #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             restart,
  output logic             tick
);
  localparam int unsigned CNT_W = 2 ** SEL_W;

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic [CNT_W:0]   one_sh;
  logic [SEL_W:0]   sh_amt;

  always_comb begin
    sh_amt = {1'b0, sel} + {{SEL_W{1'b0}}, 1'b1};
    one_sh = (CNT_W + 1)'(1) << sh_amt;
    lim    = one_sh[CNT_W-1:0] - CNT_W'(1);
    tick   = (cnt_q == lim);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (restart)   cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick) else $error("tick on consecutive cycles"); // R2

endmodule

// File: rtl/sar_fsm.sv
module sar_fsm
  import sar_pkg::*;
#(
  parameter int unsigned RES_W   = 10,
  parameter int unsigned RECOV_P = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             kill,
  input  logic             start_req,
  input  logic             abort_req,
  input  logic             cmp,
  output logic             start_ok,
  output logic             abort_ok,
  output logic             done,
  output logic             busy,
  output logic             track,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] code
);
  localparam int unsigned IDX_W = $clog2(RES_W);
  localparam int unsigned RC_W  = $clog2(RECOV_P + 1);

  sar_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [RES_W-1:0] sar_q, sar_d, trial;
  logic [RC_W-1:0]  rcnt_q, rcnt_d;

  always_comb begin
    busy     = (state_q == ST_SETUP) || (state_q == ST_BITS);
    track    = (state_q == ST_IDLE);
    start_ok = start_req && (state_q == ST_IDLE) && !kill;
    abort_ok = abort_req && busy && !kill;
    trial    = sar_q;
    trial[idx_q] = cmp;
    if (idx_q != '0) trial[idx_q - IDX_W'(1)] = 1'b1;
    done     = (state_q == ST_BITS) && tick && (idx_q == '0) && !abort_ok && !kill;
    code     = trial;
    dac_code = sar_q;
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    sar_d   = sar_q;
    rcnt_d  = rcnt_q;
    if (kill) begin
      state_d = ST_IDLE;
    end else if (abort_ok) begin
      state_d = ST_RECOV;
      rcnt_d  = '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_ok) begin
            state_d = ST_SETUP;
            sar_d   = '0;
          end
        end
        ST_SETUP: begin
          if (tick) begin
            state_d = ST_BITS;
            sar_d   = {1'b1, {(RES_W-1){1'b0}}};
            idx_d   = IDX_W'(RES_W - 1);
          end
        end
        ST_BITS: begin
          if (tick) begin
            sar_d = trial;
            if (idx_q == '0) state_d = ST_IDLE;
            else             idx_d   = idx_q - IDX_W'(1);
          end
        end
        ST_RECOV: begin
          if (tick) begin
            if (rcnt_q == RC_W'(RECOV_P - 1)) state_d = ST_IDLE;
            else                              rcnt_d  = rcnt_q + RC_W'(1);
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      sar_q   <= '0;
      rcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      sar_q   <= sar_d;
      rcnt_q  <= rcnt_d;
    end
  end

  AST_START_OPENS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (busy && !track)) else $error("start did not open hold"); // R1
  AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !kill && !abort_ok && !start_ok) |=> $stable(sar_q)) else $error("step without tick"); // R2
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (track && !busy)) else $error("completion left busy"); // R4
  AST_ABORT_RECOVERS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ok |=> (!busy && !track)) else $error("abort did not enter recovery"); // R8
  AST_KILL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !busy) else $error("busy while disabled"); // R12

endmodule

// File: rtl/sar_regs.sv
module sar_regs
  import sar_pkg::*;
#(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned DIV_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              busy,
  input  logic              done,
  input  logic              abort_ok,
  input  logic [RES_W-1:0]  code,
  output logic              en_q,
  output logic [DIV_W-1:0]  div_q,
  output logic              irq_q,
  output logic              start_req,
  output logic              abort_req
);
  localparam int unsigned RES_PAIR_W = 2 * BYTE_W;
  localparam int unsigned PAD        = RES_PAIR_W - RES_W;

  logic                  fmt_q, fmt_d, en_d, irq_d, ctrl_wr;
  logic [DIV_W-1:0]      div_d;
  logic [RES_PAIR_W-1:0] res_q, res_d, just;
  logic                  unused_wbits;

  assign unused_wbits = ^wdata;

  always_comb begin
    ctrl_wr   = wr_en && (addr == ADDR_CTRL);
    start_req = ctrl_wr && wdata[CB_GO] && wdata[CB_EN] && en_q;
    abort_req = ctrl_wr && !wdata[CB_GO];
    if (fmt_q) just = {{PAD{1'b0}}, code};
    else       just = {code, {PAD{1'b0}}};
  end

  always_comb begin
    en_d  = ctrl_wr ? wdata[CB_EN]  : en_q;
    fmt_d = ctrl_wr ? wdata[CB_FMT] : fmt_q;
    div_d = ctrl_wr ? wdata[CB_DIV +: DIV_W] : div_q;
    if (done)                         irq_d = 1'b1;
    else if (ctrl_wr && !wdata[CB_IRQ]) irq_d = 1'b0;
    else                              irq_d = irq_q;
    res_d = res_q;
    if (done) begin
      res_d = just;
    end else if (wr_en && !en_q) begin
      if (addr == ADDR_RHI) res_d[RES_PAIR_W-1:BYTE_W] = wdata;
      if (addr == ADDR_RLO) res_d[BYTE_W-1:0]          = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      fmt_q <= 1'b0;
      div_q <= '0;
      irq_q <= 1'b0;
      res_q <= '0;
    end else begin
      en_q  <= en_d;
      fmt_q <= fmt_d;
      div_q <= div_d;
      irq_q <= irq_d;
      res_q <= res_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_CTRL: begin
        rdata[CB_GO]            = busy;
        rdata[CB_EN]            = en_q;
        rdata[CB_FMT]           = fmt_q;
        rdata[CB_DIV +: DIV_W]  = div_q;
        rdata[CB_IRQ]           = irq_q;
      end
      ADDR_RHI: rdata = res_q[RES_PAIR_W-1:BYTE_W];
      ADDR_RLO: rdata = res_q[BYTE_W-1:0];
      default:  rdata = '0;
    endcase
  end

  AST_ABORT_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ok |=> $stable(res_q)) else $error("abort touched result"); // R7
  AST_RESULT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && en_q && (addr != ADDR_CTRL) && !done) |=> $stable(res_q)) else $error("result written while enabled"); // R9
  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> irq_q) else $error("flag not set on completion"); // R11

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_pkg::*;
#(
  parameter int unsigned RES_W   = 10,
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned DIV_W   = 2,
  parameter int unsigned RECOV_P = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              cmp_hi,
  output logic [RES_W-1:0]  dac_code,
  output logic              sh_track,
  output logic              irq
);
  logic             rst_s1, rst_sn;
  logic             tick, start_req, abort_req, start_ok, abort_ok;
  logic             done, busy, en_q, irq_q;
  logic [DIV_W-1:0] div_q;
  logic [RES_W-1:0] code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  sar_clkdiv #(.SEL_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_sn),
    .sel     (div_q),
    .restart (start_ok || abort_ok),
    .tick    (tick)
  );

  sar_fsm #(.RES_W(RES_W), .RECOV_P(RECOV_P)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sn),
    .tick      (tick),
    .kill      (!en_q),
    .start_req (start_req),
    .abort_req (abort_req),
    .cmp       (cmp_hi),
    .start_ok  (start_ok),
    .abort_ok  (abort_ok),
    .done      (done),
    .busy      (busy),
    .track     (sh_track),
    .dac_code  (dac_code),
    .code      (code)
  );

  sar_regs #(.RES_W(RES_W), .BYTE_W(BYTE_W), .DIV_W(DIV_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sn),
    .wr_en     (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .busy      (busy),
    .done      (done),
    .abort_ok  (abort_ok),
    .code      (code),
    .en_q      (en_q),
    .div_q     (div_q),
    .irq_q     (irq_q),
    .start_req (start_req),
    .abort_req (abort_req)
  );

  assign irq = irq_q;

endmodule

// File: tb/tb_sar_seq_top.sv
module tb_sar_seq_top;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, reg_wr, cmp_hi, sh_track, irq;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [9:0] dac_code, vin;
  int total, fails, cyc;

  sar_seq_top dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_hi(cmp_hi),
    .dac_code(dac_code), .sh_track(sh_track), .irq(irq)
  );

  assign cmp_hi = (vin >= dac_code);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      total = total + 1;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cw(input bit go, input bit en, input bit fmt,
                                    input int div, input bit keep);
    logic [7:0] w;
    w = 8'h00;
    w[0] = go; w[1] = en; w[2] = fmt; w[4:3] = 2'(div); w[7] = keep;
    return w;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle(inout int n);
    logic [7:0] c;
    rd(2'd0, c);
    while (c[0] && n < 400) begin
      @(negedge clk);
      n = n + 1;
      rd(2'd0, c);
    end
  endtask

  task automatic read_res(output logic [15:0] r);
    logic [7:0] h, l;
    rd(2'd2, h);
    rd(2'd3, l);
    r = {h, l};
  endtask

  task automatic convert(input bit fmt, input int div, input logic [9:0] v,
                         input bit keep, output int n, output logic [15:0] r);
    vin = v;
    wr(2'd0, cw(1, 1, fmt, div, keep));
    n = 0;
    wait_idle(n);
    read_res(r);
  endtask

  initial begin
    logic [7:0]  c, h;
    logic [15:0] r, saved;
    int n;
    total = 0; fails = 0; cyc = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00; vin = 10'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    rd(2'd0, c); chk("reset ctrl", c, 0);
    read_res(r); chk("reset result", r, 0);
    chk("reset track", sh_track, 1);
    chk("reset irq", irq, 0);

    // R12: go while disabled
    wr(2'd0, cw(1, 0, 1, 0, 0));
    rd(2'd0, c); chk("R12 busy", c[0], 0);
    repeat (5) @(negedge clk);
    chk("R12 track", sh_track, 1);

    // R9: storage while disabled
    wr(2'd2, 8'hA5);
    wr(2'd3, 8'h3C);
    read_res(r); chk("R9 storage", r, 16'hA53C);

    // R10: go in the enabling write
    wr(2'd0, cw(1, 1, 1, 0, 0));
    rd(2'd0, c); chk("R10 busy", c[0], 0);
    repeat (30) @(negedge clk);
    read_res(r); chk("R10 result untouched", r, 16'hA53C);
    chk("R10 track", sh_track, 1);

    // R9: writes ignored while enabled
    wr(2'd2, 8'h11);
    wr(2'd3, 8'h22);
    read_res(r); chk("R9 locked", r, 16'hA53C);

    // R1, R3 trial sequence, R2, R4, R5 on one code
    vin = 10'd700;
    wr(2'd0, cw(1, 1, 1, 0, 0));
    rd(2'd0, c); chk("R1 busy", c[0], 1);
    chk("R1 track", sh_track, 0);
    chk("R3 setup dac", dac_code, 0);
    repeat (2) @(negedge clk);
    chk("R3 first trial", dac_code, 512);
    repeat (2) @(negedge clk);
    chk("R3 second trial", dac_code, 768);
    n = 4;
    wait_idle(n);
    chk("R2 length div2", n, 22);
    rd(2'd0, c); chk("R4 flag bit", c[7], 1);
    chk("R4 irq", irq, 1);
    chk("R4 track", sh_track, 1);
    read_res(r); chk("R4 R5 result", r, 700);

    // R3 R5: every code, right justified
    for (int v = 0; v < 1024; v++) begin
      convert(1, 0, 10'(v), 0, n, r);
      chk("R3 R5 sweep", r, v);
      chk("R2 sweep length", n, 22);
    end

    // R6: left justified
    for (int v = 0; v < 1024; v += 31) begin
      convert(0, 0, 10'(v), 0, n, r);
      chk("R6 left", r, v << 6);
    end
    convert(0, 0, 10'd1023, 0, n, r);
    chk("R6 left full", r, 16'hFFC0);

    // R2: other divider settings
    for (int d = 1; d < 4; d++) begin
      convert(1, d, 10'h2AA, 0, n, r);
      chk("R2 length", n, 11 * (2 << d));
      chk("R2 result", r, 16'h02AA);
    end

    // R11: flag behaviour
    wr(2'd0, cw(0, 1, 1, 0, 1));
    chk("R11 write one keeps", irq, 1);
    wr(2'd0, cw(0, 1, 1, 0, 0));
    chk("R11 write zero clears", irq, 0);
    convert(1, 0, 10'd5, 0, n, r);
    chk("R11 set", irq, 1);
    convert(1, 0, 10'd6, 1, n, r);
    chk("R11 set again", irq, 1);
    wr(2'd0, cw(0, 1, 1, 0, 0));
    chk("R11 cleared", irq, 0);

    // R7 R8: abort then recovery
    read_res(saved);
    vin = 10'd100;
    wr(2'd0, cw(1, 1, 1, 0, 0));
    repeat (7) @(negedge clk);
    wr(2'd0, cw(0, 1, 1, 0, 0));
    rd(2'd0, c); chk("R7 busy", c[0], 0);
    for (int k = 0; k < 4; k++) begin
      chk("R8 hold open", sh_track, 0);
      @(negedge clk);
    end
    chk("R8 hold closes", sh_track, 1);
    read_res(r); chk("R7 result kept", r, saved);
    chk("R7 no flag", irq, 0);

    // R8: start during recovery ignored
    vin = 10'd900;
    wr(2'd0, cw(1, 1, 1, 0, 0));
    repeat (5) @(negedge clk);
    wr(2'd0, cw(0, 1, 1, 0, 0));
    wr(2'd0, cw(1, 1, 1, 0, 0));
    rd(2'd0, c); chk("R8 start ignored", c[0], 0);
    repeat (30) @(negedge clk);
    read_res(r); chk("R8 result kept", r, saved);
    chk("R8 no flag", irq, 0);

    // R9: disabled again, storage writable
    wr(2'd0, cw(0, 0, 1, 0, 0));
    wr(2'd2, 8'h5A);
    wr(2'd3, 8'hC3);
    read_res(r); chk("R9 storage again", r, 16'h5AC3);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule